// File: doc/BRIEF.md
# Synchronous Burst SRAM Controller

This block is a cycle-level model of a pipelined synchronous SRAM whose 32-bit data path is shared between reads and writes. Every control input is sampled on the rising clock edge. Two address strobes start an access. The processor strobe is obeyed only while chip select 1 is active. The controller strobe acts whenever the processor strobe is not in effect. Three chip selects qualify a strobe. When a strobe arrives while any chip select is inactive, the device deselects.

While selected, cycles with no strobe continue the current access. The advance input either holds the burst address or steps it through a two-bit wraparound sequence. The sequence is linear or interleaved, chosen when the address is loaded. Writes go to all bytes when the global write is low, or only to the selected bytes when the byte-write enable is low. Read data comes out of an output register. `drive_en` stands in for the three-state control of the shared bus: it is high only when the bus would actually be driven.

Top module: `sbs_sram`

## Requirements
- R1: After reset no access is in progress and `drive_en` is 0; cycles with no strobe perform no access until one is accepted.
- R2: A strobe accepted while selected (`cs1_n`=0, `cs2`=1, `cs3_n`=0) is a read unless it is a controller-strobe write. The data word at the access address appears on `rdata` after the clock edge that accepts the access, and stays there until the next read.
- R3: `proc_stb_n` is ignored while `cs1_n` is 1. That cycle then behaves as if the processor strobe were high, so the controller strobe may act or the burst may continue.
- R4: A controller-strobe access with `gwr_n`=0 or `bwen_n`=0 writes `wdata` at `addr` in that single cycle, and `adv_n` has no effect on that cycle.
- R5: A processor-strobe access ignores `gwr_n`, `bwen_n`, `bsel_n` and `adv_n` on its first cycle and only reads. A write requested on the following no-strobe cycle with `adv_n`=1 stores `wdata` at the loaded address.
- R6: `gwr_n`=0 writes all four bytes whatever `bsel_n` holds. Otherwise `bwen_n`=0 writes byte i (`wdata[8i+7:8i]`) only where `bsel_n[i]`=0, and the other bytes keep their contents.
- R7: On a no-strobe cycle of a selected session, `adv_n`=0 moves to the next burst address before the access and `adv_n`=1 repeats the current one. The upper address bits never change within a burst. With `lin_mode`=1 at load, the low two bits are (base+k) mod 4; with `lin_mode`=0 they are base XOR k, where k counts the advances.
- R8: `drive_en` is 0 during any cycle that requests a write, whatever `oe_n` holds. Otherwise it is high only if `oe_n`=0 and valid read data is in the output register.
- R9: A strobe seen while any chip select is inactive ends the session and turns the drive off at that edge. The first read after a deselected period leaves the bus undriven during its output cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| addr | input | 17 | Word address loaded by an accepted strobe |
| proc_stb_n | input | 1 | Processor address strobe, active low |
| ctl_stb_n | input | 1 | Controller address strobe, active low |
| cs1_n | input | 1 | Chip select 1, active low; also gates the processor strobe |
| cs2 | input | 1 | Chip select 2, active high |
| cs3_n | input | 1 | Chip select 3, active low |
| gwr_n | input | 1 | Global write, active low, all bytes |
| bwen_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | 4 | Per-byte write selects, active low, bit i for byte i |
| adv_n | input | 1 | Burst advance, active low |
| lin_mode | input | 1 | Burst order at load: 1 linear, 0 interleaved |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Output register contents |
| drive_en | output | 1 | High when the shared data bus is driven |

## Verification
The hardest case to reach is the processor-strobe write. It needs an accepted strobe that carries write requests, which must be ignored, followed by a no-strobe cycle with the write inputs active and the advance held. Random stimulus rarely produces that pairing, and almost never followed by a readback of the same word. Directed sequences build it on purpose, together with reselection after a deselect and both burst orders from a nonzero start address. Biased random cycles then mix strobes, chip-select drops, byte masks and advance against a bench reference memory.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int BYTE_W = 8;
  localparam int SEQ_W  = 2;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_READ,
    ACC_WRITE,
    ACC_DESEL
  } acc_e;

  // low address bits of burst step k from start value base
  function automatic logic [SEQ_W-1:0] burst_lo(input logic [SEQ_W-1:0] base,
                                                input logic [SEQ_W-1:0] k,
                                                input logic             lin);
    return lin ? SEQ_W'(base + k) : (base ^ k);
  endfunction
endpackage

// File: rtl/sbs_burst_seq.sv
module sbs_burst_seq
  import sbs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [SEQ_W-1:0] base_in,
  input  logic             lin_in,
  output logic [SEQ_W-1:0] cur_lo,
  output logic [SEQ_W-1:0] nxt_lo
);
  logic [SEQ_W-1:0] base_q, base_d, cnt_q, cnt_d;
  logic             lin_q, lin_d;

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    lin_d  = lin_q;
    if (load) begin
      base_d = base_in;
      cnt_d  = '0;
      lin_d  = lin_in;
    end else if (step) begin
      cnt_d = SEQ_W'(cnt_q + 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      lin_q  <= 1'b1;
    end else if (load || step) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
      lin_q  <= lin_d;
    end
  end

  assign cur_lo = burst_lo(base_q, cnt_q, lin_q);
  assign nxt_lo = burst_lo(base_q, SEQ_W'(cnt_q + 1'b1), lin_q);

  // R7: an advance without a load moves the step count by exactly one
  a_r7_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (cnt_q == SEQ_W'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/sbs_mem.sv
module sbs_mem
  import sbs_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 256,
  localparam int NB   = DW / BYTE_W,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [NB-1:0] be,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [BYTE_W-1:0] lane [DEPTH];

    always_ff @(posedge clk) begin
      if (we && be[b]) lane[idx] <= wdata[b*BYTE_W +: BYTE_W];
    end

    assign rdata[b*BYTE_W +: BYTE_W] = lane[idx];
  end
endmodule

// File: rtl/sbs_sram.sv
module sbs_sram
  import sbs_pkg::*;
#(
  parameter int AW    = 17,
  parameter int DW    = 32,
  parameter int DEPTH = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic              proc_stb_n,
  input  logic              ctl_stb_n,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              cs3_n,
  input  logic              gwr_n,
  input  logic              bwen_n,
  input  logic [DW/8-1:0]   bsel_n,
  input  logic              adv_n,
  input  logic              lin_mode,
  input  logic              oe_n,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              drive_en
);
  localparam int NB = DW / BYTE_W;
  localparam int IW = $clog2(DEPTH);
  localparam int UW = AW - SEQ_W;

  logic             sel, p_act, c_act, strobe, wr_req;
  logic             seq_load, seq_step;
  logic [NB-1:0]    be;
  acc_e             acc;
  logic [AW-1:0]    eff_addr;
  logic [SEQ_W-1:0] cur_lo, nxt_lo;
  logic             act_q, act_d, drv_q, drv_d;
  logic [UW-1:0]    up_q, up_d;
  logic [DW-1:0]    rd_q, mem_rd;

  // access decode
  always_comb begin
    sel      = !cs1_n && cs2 && !cs3_n;
    p_act    = !proc_stb_n && !cs1_n;
    c_act    = !ctl_stb_n && !p_act;
    strobe   = p_act || c_act;
    wr_req   = !gwr_n || !bwen_n;
    be       = !gwr_n ? '1 : (!bwen_n ? ~bsel_n : '0);
    acc      = ACC_NONE;
    if (strobe && !sel)  acc = ACC_DESEL;
    else if (strobe)     acc = (c_act && wr_req) ? ACC_WRITE : ACC_READ;
    else if (act_q)      acc = wr_req ? ACC_WRITE : ACC_READ;
    seq_load = strobe && sel;
    seq_step = !strobe && act_q && !adv_n;
    eff_addr = seq_load ? addr : {up_q, (adv_n ? cur_lo : nxt_lo)};
  end

  // next state
  always_comb begin
    act_d = act_q;
    if (seq_load)              act_d = 1'b1;
    else if (acc == ACC_DESEL) act_d = 1'b0;
    drv_d = (acc == ACC_READ) && act_q;
    up_d  = seq_load ? addr[AW-1:SEQ_W] : up_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      drv_q <= 1'b0;
      up_q  <= '0;
    end else begin
      act_q <= act_d;
      drv_q <= drv_d;
      if (seq_load) up_q <= up_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rd_q <= '0;
    else if (acc == ACC_READ)  rd_q <= mem_rd;
  end

  sbs_burst_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (seq_load),
    .step    (seq_step),
    .base_in (addr[SEQ_W-1:0]),
    .lin_in  (lin_mode),
    .cur_lo  (cur_lo),
    .nxt_lo  (nxt_lo)
  );

  sbs_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (acc == ACC_WRITE),
    .be    (be),
    .idx   (eff_addr[IW-1:0]),
    .wdata (wdata),
    .rdata (mem_rd)
  );

  assign rdata    = rd_q;
  assign drive_en = drv_q && !oe_n && (acc != ACC_WRITE);

  // R1: without a session the output register never counts as driven
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |-> !drv_q);

  // R9: a deselect ends the session and drops the drive at that edge
  a_r9_desel_off: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == ACC_DESEL) |=> (!drv_q && !act_q && !drive_en));

  // R9: reselection from idle keeps the bus undriven for one cycle
  a_r9_reselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_load && !act_q) |=> !drive_en);

  // R2: a read inside a running session yields valid output data next cycle
  a_r2_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == ACC_READ && act_q) |=> drv_q);

  // R8: a write cycle leaves the output register untouched
  a_r8_write_holds_rdata: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == ACC_WRITE) |=> $stable(rdata));
endmodule

// File: tb/sim_sbs_sram.sv
module sim_sbs_sram;
  localparam int AW = 17, DW = 32, DEPTH = 256, NB = DW / 8;

  logic clk, rst_n;
  logic [AW-1:0] addr;
  logic proc_stb_n, ctl_stb_n, cs1_n, cs2, cs3_n, gwr_n, bwen_n, adv_n, lin_mode, oe_n;
  logic [NB-1:0] bsel_n;
  logic [DW-1:0] wdata, rdata;
  logic drive_en;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  sbs_sram #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .proc_stb_n(proc_stb_n), .ctl_stb_n(ctl_stb_n),
    .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .gwr_n(gwr_n), .bwen_n(bwen_n), .bsel_n(bsel_n),
    .adv_n(adv_n), .lin_mode(lin_mode), .oe_n(oe_n), .wdata(wdata), .rdata(rdata),
    .drive_en(drive_en));

  int n_vec = 0, n_bad = 0;
  logic done = 1'b0;

  // reference state, built from the requirements
  logic [DW-1:0] ref_mem [DEPTH];
  logic m_act = 1'b0, m_drv = 1'b0, m_lin = 1'b1;
  logic [AW-3:0] m_up = '0;
  logic [1:0] m_base = '0, m_k = '0;
  logic [DW-1:0] m_rd = '0;

  function automatic logic [1:0] seq_lo(logic [1:0] b, logic [1:0] k, logic lin);
    return lin ? 2'(b + k) : (b ^ k);
  endfunction

  // expectation for the current inputs: kind 0 none, 1 read, 2 write, 3 deselect
  logic e_sel, e_p, e_c, e_stb, e_start, e_cont, e_wr, e_drive;
  int e_kind;
  logic [NB-1:0] e_be;
  logic [AW-1:0] e_eff;
  always_comb begin
    e_sel   = (cs1_n == 1'b0) && (cs2 == 1'b1) && (cs3_n == 1'b0);
    e_p     = (proc_stb_n == 1'b0) && (cs1_n == 1'b0);
    e_c     = (ctl_stb_n == 1'b0) && !e_p;
    e_stb   = e_p || e_c;
    e_start = e_stb && e_sel;
    e_cont  = !e_stb && m_act;
    e_wr    = (gwr_n == 1'b0) || (bwen_n == 1'b0);
    e_be    = (gwr_n == 1'b0) ? {NB{1'b1}} : ((bwen_n == 1'b0) ? ~bsel_n : '0);
    if (e_stb && !e_sel)  e_kind = 3;
    else if (e_start)     e_kind = (e_c && e_wr) ? 2 : 1;
    else if (e_cont)      e_kind = e_wr ? 2 : 1;
    else                  e_kind = 0;
    if (e_start) e_eff = addr;
    else e_eff = {m_up, seq_lo(m_base, (adv_n == 1'b0) ? 2'(m_k + 1) : m_k, m_lin)};
    e_drive = m_drv && (oe_n == 1'b0) && (e_kind != 2);
  end

  task automatic model_edge();
    int kind = e_kind;
    logic [AW-1:0] eff = e_eff;
    logic [NB-1:0] be = e_be;
    logic start = e_start, cont = e_cont;
    if (kind == 2)
      for (int b = 0; b < NB; b++)
        if (be[b]) ref_mem[eff[7:0]][b*8 +: 8] = wdata[b*8 +: 8];
    if (kind == 1) m_rd = ref_mem[eff[7:0]];
    m_drv = (kind == 1) && m_act;
    if (start) begin
      m_up = addr[AW-1:2]; m_base = addr[1:0]; m_k = '0; m_lin = lin_mode; m_act = 1'b1;
    end else if (kind == 3) begin
      m_act = 1'b0;
    end else if (cont && adv_n == 1'b0) begin
      m_k = 2'(m_k + 1);
    end
  endtask

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(string req);
    #1;
    check({req, " drive_en"}, DW'(drive_en), DW'(e_drive));
    @(posedge clk);
    model_edge();
    @(negedge clk);
    #1;
    if (m_drv) check({req, " rdata"}, rdata, m_rd);
  endtask

  task automatic idle();
    proc_stb_n = 1; ctl_stb_n = 1; cs1_n = 0; cs2 = 1; cs3_n = 0;
    gwr_n = 1; bwen_n = 1; bsel_n = '1; adv_n = 1; oe_n = 0; lin_mode = 1;
    addr = '0; wdata = '0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 drive in reset", DW'(drive_en), '0);
    rst_n = 1'b1;
    tick("R1 no access after reset");
    tick("R1 still idle");

    // fill memory with controller-strobe global writes
    for (int i = 0; i < DEPTH; i++) begin
      idle(); ctl_stb_n = 0; gwr_n = 0; addr = AW'(i); wdata = $urandom;
      tick("R4 fill");
    end

    // deselect, then reselect with a read
    idle(); ctl_stb_n = 0; cs2 = 0; tick("R9 deselect");
    idle(); tick("R9 idle after deselect");
    idle(); ctl_stb_n = 0; addr = 17'h1_0005; tick("R9 reselect read");
    idle(); tick("R9 first cycle quiet");
    idle(); tick("R2 read data driven");
    idle(); oe_n = 1; tick("R8 oe gates drive");

    // linear burst from low bits 2
    idle(); proc_stb_n = 0; addr = 17'h0_0042; lin_mode = 1; tick("R7 linear load");
    for (int i = 0; i < 3; i++) begin idle(); adv_n = 0; tick("R7 linear step"); end
    // interleaved burst from low bits 1
    idle(); proc_stb_n = 0; addr = 17'h0_0071; lin_mode = 0; tick("R7 interleaved load");
    for (int i = 0; i < 3; i++) begin idle(); adv_n = 0; tick("R7 interleaved step"); end
    idle(); adv_n = 1; tick("R7 hold");

    // processor strobe: first-cycle write request ignored
    idle(); proc_stb_n = 0; addr = 17'h0_0044; gwr_n = 0; wdata = 32'hDEAD_BEEF;
    tick("R5 first cycle reads");
    idle(); tick("R5 first cycle wrote nothing");
    // processor-strobe two-cycle write
    idle(); proc_stb_n = 0; addr = 17'h0_0033; gwr_n = 0; wdata = 32'hAAAA_AAAA;
    tick("R5 load");
    idle(); gwr_n = 0; wdata = 32'h1234_5678; tick("R5 second cycle write");
    idle(); tick("R5 readback");
    idle(); tick("R5 readback driven");

    // byte writes and global override
    idle(); ctl_stb_n = 0; addr = 17'h0_0090; bwen_n = 0; bsel_n = 4'b1010; wdata = 32'hA1B2_C3D4;
    tick("R6 byte select write");
    idle(); tick("R6 readback");
    idle(); tick("R6 readback driven");
    idle(); ctl_stb_n = 0; addr = 17'h0_0091; gwr_n = 0; bwen_n = 0; bsel_n = 4'b1111; wdata = 32'h5566_7788;
    tick("R6 global overrides selects");
    idle(); tick("R6 global readback");
    idle(); tick("R6 global readback driven");

    // controller-strobe write ignores advance
    idle(); ctl_stb_n = 0; addr = 17'h0_00A2; gwr_n = 0; adv_n = 0; wdata = 32'h0BAD_F00D;
    tick("R4 advance ignored");
    idle(); tick("R4 readback");
    idle(); tick("R4 readback driven");

    // processor strobe ignored when chip select 1 inactive
    idle(); proc_stb_n = 0; cs1_n = 1; addr = 17'h0_0010; tick("R3 strobe ignored");
    idle(); tick("R3 session continues");
    idle(); proc_stb_n = 0; ctl_stb_n = 0; cs1_n = 1; tick("R3 controller deselects");
    idle(); tick("R3 idle after deselect");

    // write request forces drive off
    idle(); proc_stb_n = 0; addr = 17'h0_0020; tick("R8 load");
    idle(); tick("R8 read");
    idle(); bwen_n = 0; bsel_n = 4'hE; wdata = 32'hCAFE_0001; tick("R8 write forces off");
    idle(); tick("R8 after write");
    idle(); tick("R8 after write driven");

    // biased random traffic
    for (int i = 0; i < 4000; i++) begin
      cs1_n      = ($urandom_range(0, 19) == 0);
      cs2        = ($urandom_range(0, 19) != 0);
      cs3_n      = ($urandom_range(0, 19) == 0);
      proc_stb_n = ($urandom_range(0, 5) != 0);
      ctl_stb_n  = ($urandom_range(0, 5) != 0);
      gwr_n      = ($urandom_range(0, 4) != 0);
      bwen_n     = ($urandom_range(0, 3) != 0);
      bsel_n     = NB'($urandom);
      adv_n      = 1'($urandom_range(0, 1));
      oe_n       = ($urandom_range(0, 5) == 0);
      lin_mode   = 1'($urandom_range(0, 1));
      addr       = AW'($urandom);
      wdata      = $urandom;
      tick("R2 R6 R7 R8 random");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule